// File: doc/BRIEF.md
# Tagged Fan-In / Fan-Out Adder Pipeline

This block lets several independent requesters share one multi-stage adder. Each request port offers two operands under a valid/ready handshake. A round-robin arbiter grants one port per cycle. The operands are summed, and the grant index is stored beside the sum as a routing tag. The tag moves through every pipeline slot unchanged. At the tail, a router uses the tag to present the result on the response port with the same index. Each response port has its own valid/ready handshake.

Every pipeline slot is a two-state machine. `SLOT_EMPTY` moves to `SLOT_FULL` when upstream offers an item. `SLOT_FULL` stays full while it passes its item on and takes a new one. It returns to `SLOT_EMPTY` when it passes its item on and nothing new arrives. It holds while the slot after it cannot take. A full slot passes its item on only when the next slot is empty or passing, so an empty slot behind a blocked head still fills. The head slot passes only when the response port named by its tag is ready.

Top module: `fanpipe_top`

## Requirements
- R1: A transfer takes place only on a rising edge where valid and ready are both high on the same port, on both the request side and the response side.
- R2: At most one `in_ready` bit is high in any cycle, and only for a port whose `in_valid` is high.
- R3: Arbitration is round-robin. After reset the search starts at port 0. After a port is accepted, the search starts at the next higher index, wrapping to 0. A port that was just accepted is not granted again in the next cycle while another port is valid.
- R4: The result is `z = (a + b) mod 2^WIDTH`. For example, 0xFFFF + 0x0001 gives 0x0000 with WIDTH=16.
- R5: A result appears only on the response port whose index equals the request port it came from. Its `out_tag` equals that index.
- R6: At most one `out_valid` bit is high in any cycle.
- R7: While a response port shows valid with ready low, its valid, `out_z` and `out_tag` hold unchanged into the next cycle.
- R8: Results on each response port appear in the order in which that port's requests were accepted.
- R9: If the head result is blocked, the pipeline holds at most STAGES items. Once every slot is full, every `in_ready` stays low.
- R10: An empty slot behind a blocked head still accepts a new request.
- R11: A synchronous active-high `rst` empties every slot, so all `out_valid` bits are low after it, and resets the arbiter search start to port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Request valid, one bit per port |
| in_ready | output | NPORT | Request ready, one bit per port |
| in_a | input | NPORT x WIDTH | First operand for each port |
| in_b | input | NPORT x WIDTH | Second operand for each port |
| out_valid | output | NPORT | Response valid, one bit per port |
| out_ready | input | NPORT | Response ready, one bit per port |
| out_z | output | NPORT x WIDTH | Sum shown on each response port |
| out_tag | output | NPORT x TAGW | Routing tag shown on each response port |

## Verification
The bound checker watches every cycle for the following:
- the single grant to a valid port;
- a port winning twice in a row while another port waits;
- more than one response valid;
- a tag that does not match its port;
- a held response that changes while stalled;
- a valid response right after reset.

Other properties depend on history that only the bench's scenarios expose:
- the exact grant order;
- the sum and its wraparound;
- per-port ordering under random gaps and random backpressure;
- the count of items absorbed behind a blocked head;
- bubble filling behind that head;
- the effect of reset on items in flight.

// File: rtl/fanpipe_pkg.sv
package fanpipe_pkg;

    // Occupancy state of one pipeline slot
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // Bits needed to carry a port index
    function automatic int tag_bits(input int nports);
        return (nports > 1) ? $clog2(nports) : 1;
    endfunction

endpackage

// File: rtl/fanpipe_arbiter.sv
module fanpipe_arbiter #(
    parameter int NPORT = 4,
    parameter int TAGW  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  logic             take,
    output logic             grant_any,
    output logic [TAGW-1:0]  grant_idx
);

    logic [TAGW-1:0] ptr_q;

    // Search start pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take) begin
            if (int'(grant_idx) == NPORT - 1) ptr_q <= '0;
            else                              ptr_q <= grant_idx + TAGW'(1);
        end
    end

    // First requester at or after the pointer
    always_comb begin
        int cand;
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < NPORT; k++) begin
            cand = int'(ptr_q) + k;
            if (cand >= NPORT) cand = cand - NPORT;
            if (!grant_any && req[cand]) begin
                grant_any = 1'b1;
                grant_idx = TAGW'(cand);
            end
        end
    end

endmodule

// File: rtl/fanpipe_stage.sv
module fanpipe_stage
    import fanpipe_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int TAGW  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    input  logic [WIDTH-1:0] up_z,
    input  logic [TAGW-1:0]  up_tag,
    input  logic             pass,
    output logic             full,
    output logic [WIDTH-1:0] z,
    output logic [TAGW-1:0]  tag
);

    slot_state_e state_q, state_d;
    logic        load;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_EMPTY;
        else     state_q <= state_d;
    end

    // Next state and load enable
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                load = up_valid;
                if (up_valid) state_d = SLOT_FULL;
            end
            SLOT_FULL: begin
                if (pass) begin
                    load    = up_valid;
                    state_d = up_valid ? SLOT_FULL : SLOT_EMPTY;
                end
            end
        endcase
    end

    // Payload, written only when a real item enters
    always_ff @(posedge clk) begin
        if (load) begin
            z   <= up_z;
            tag <= up_tag;
        end
    end

    assign full = (state_q == SLOT_FULL);

endmodule

// File: rtl/fanpipe_router.sv
module fanpipe_router #(
    parameter int NPORT = 4,
    parameter int WIDTH = 16,
    parameter int TAGW  = 2
) (
    input  logic                        head_full,
    input  logic [WIDTH-1:0]            head_z,
    input  logic [TAGW-1:0]             head_tag,
    input  logic [NPORT-1:0]            out_ready,
    output logic [NPORT-1:0]            out_valid,
    output logic [NPORT-1:0][WIDTH-1:0] out_z,
    output logic [NPORT-1:0][TAGW-1:0]  out_tag,
    output logic                        head_pass
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign out_valid[p] = head_full && (head_tag == TAGW'(p));
        assign out_z[p]     = head_z;
        assign out_tag[p]   = head_tag;
    end

    assign head_pass = |(out_valid & out_ready);

endmodule

// File: rtl/fanpipe_top.sv
module fanpipe_top
    import fanpipe_pkg::*;
#(
    parameter int  NPORT  = 4,
    parameter int  WIDTH  = 16,
    parameter int  STAGES = 2,
    localparam int TAGW   = tag_bits(NPORT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORT-1:0]            in_valid,
    output logic [NPORT-1:0]            in_ready,
    input  logic [NPORT-1:0][WIDTH-1:0] in_a,
    input  logic [NPORT-1:0][WIDTH-1:0] in_b,
    output logic [NPORT-1:0]            out_valid,
    input  logic [NPORT-1:0]            out_ready,
    output logic [NPORT-1:0][WIDTH-1:0] out_z,
    output logic [NPORT-1:0][TAGW-1:0]  out_tag
);

    localparam int LAST = STAGES - 1;

    logic                         grant_any;
    logic [TAGW-1:0]              grant_idx;
    logic                         entry_open;
    logic                         take;
    logic [WIDTH-1:0]             entry_sum;
    logic                         head_pass;
    logic [STAGES-1:0]            st_full;
    logic [STAGES-1:0]            st_pass;
    logic [STAGES-1:0][WIDTH-1:0] st_z;
    logic [STAGES-1:0][TAGW-1:0]  st_tag;

    fanpipe_arbiter #(.NPORT(NPORT), .TAGW(TAGW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (in_valid),
        .take      (take),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    assign take      = grant_any && entry_open;
    assign entry_sum = in_a[grant_idx] + in_b[grant_idx];

    for (genvar p = 0; p < NPORT; p++) begin : g_ready
        assign in_ready[p] = take && (grant_idx == TAGW'(p));
    end

    // Backward ready chain: a slot can move when empty or passing on
    always_comb begin
        logic carry;
        carry = head_pass;
        for (int i = LAST; i >= 0; i--) begin
            st_pass[i] = carry;
            carry      = !st_full[i] || carry;
        end
        entry_open = carry;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic             up_v;
        logic [WIDTH-1:0] up_zv;
        logic [TAGW-1:0]  up_t;
        if (i == 0) begin : g_entry
            assign up_v  = grant_any;
            assign up_zv = entry_sum;
            assign up_t  = grant_idx;
        end else begin : g_chain
            assign up_v  = st_full[i-1];
            assign up_zv = st_z[i-1];
            assign up_t  = st_tag[i-1];
        end
        fanpipe_stage #(.WIDTH(WIDTH), .TAGW(TAGW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .up_valid (up_v),
            .up_z     (up_zv),
            .up_tag   (up_t),
            .pass     (st_pass[i]),
            .full     (st_full[i]),
            .z        (st_z[i]),
            .tag      (st_tag[i])
        );
    end

    fanpipe_router #(.NPORT(NPORT), .WIDTH(WIDTH), .TAGW(TAGW)) u_route (
        .head_full (st_full[LAST]),
        .head_z    (st_z[LAST]),
        .head_tag  (st_tag[LAST]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_z     (out_z),
        .out_tag   (out_tag),
        .head_pass (head_pass)
    );

endmodule

// File: rtl/fanpipe_checker.sv
module fanpipe_checker #(
    parameter int NPORT = 4,
    parameter int WIDTH = 16,
    parameter int TAGW  = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NPORT-1:0]            in_valid,
    input logic [NPORT-1:0]            in_ready,
    input logic [NPORT-1:0]            out_valid,
    input logic [NPORT-1:0]            out_ready,
    input logic [NPORT-1:0][WIDTH-1:0] out_z,
    input logic [NPORT-1:0][TAGW-1:0]  out_tag
);

    // R2
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready));

    // R2
    a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~in_valid) == '0);

    // R6
    a_r6_one_response: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    // R11
    a_r11_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> out_valid == '0);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // R5
        a_r5_tag_matches: assert property (@(posedge clk) disable iff (rst)
            out_valid[p] |-> out_tag[p] == TAGW'(p));

        // R7
        a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && !out_ready[p]) |=>
                (out_valid[p] && $stable(out_z[p]) && $stable(out_tag[p])));

        // R3
        a_r3_no_repeat_grant: assert property (@(posedge clk) disable iff (rst)
            (in_valid[p] && in_ready[p]) |=>
                !(in_ready[p] && |(in_valid & ~(NPORT'(1) << p))));
    end

endmodule

bind fanpipe_top fanpipe_checker #(
    .NPORT (NPORT),
    .WIDTH (WIDTH),
    .TAGW  (TAGW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_z     (out_z),
    .out_tag   (out_tag)
);

// File: tb/fanpipe_top_tb.sv
`timescale 1ns/1ps
module fanpipe_top_tb;

    localparam int NPORT  = 4;
    localparam int WIDTH  = 16;
    localparam int STAGES = 2;
    localparam int TAGW   = 2;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NPORT-1:0]            in_valid = '0;
    logic [NPORT-1:0]            in_ready;
    logic [NPORT-1:0][WIDTH-1:0] in_a = '0;
    logic [NPORT-1:0][WIDTH-1:0] in_b = '0;
    logic [NPORT-1:0]            out_valid;
    logic [NPORT-1:0]            out_ready = '0;
    logic [NPORT-1:0][WIDTH-1:0] out_z;
    logic [NPORT-1:0][TAGW-1:0]  out_tag;

    int n_chk  = 0;
    int n_fail = 0;
    int sink_mode = 0; // 0 all ready, 1 all blocked, 2 random
    logic [WIDTH-1:0] exp_q [NPORT][$];

    always #2 clk = ~clk;

    fanpipe_top #(.NPORT(NPORT), .WIDTH(WIDTH), .STAGES(STAGES)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_z(out_z), .out_tag(out_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: offer one request, wait for acceptance, record the expected sum
    task automatic send(input int p, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        logic [WIDTH-1:0] s;
        s = a + b;
        @(negedge clk);
        in_valid[p] = 1'b1;
        in_a[p] = a;
        in_b[p] = b;
        #1;
        while (!in_ready[p]) begin
            @(negedge clk);
            #1;
        end
        exp_q[p].push_back(s);
        @(posedge clk);
        #1;
        in_valid[p] = 1'b0;
    endtask

    // Sink and scoreboard monitor
    always begin
        @(negedge clk);
        case (sink_mode)
            0:       out_ready = '1;
            1:       out_ready = '0;
            default: for (int p = 0; p < NPORT; p++) out_ready[p] = ($urandom_range(0, 3) != 0);
        endcase
        #1;
        if (!rst) begin
            for (int p = 0; p < NPORT; p++) begin
                if (out_valid[p] && out_ready[p]) begin
                    if (exp_q[p].size() == 0) begin
                        check(1'b0, "R5", $sformatf("unexpected result on port %0d", p), out_z[p], 0);
                    end else begin
                        logic [WIDTH-1:0] e;
                        e = exp_q[p].pop_front();
                        // R4 sum value, R8 per-port order
                        check(out_z[p] == e, "R4/R8", $sformatf("sum on port %0d", p), out_z[p], e);
                        check(out_tag[p] == TAGW'(p), "R5", $sformatf("tag on port %0d", p), out_tag[p], p);
                    end
                end
            end
        end
    end

    task automatic drain();
        int left;
        do begin
            @(negedge clk);
            left = 0;
            for (int p = 0; p < NPORT; p++) left += exp_q[p].size();
        end while (left != 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == '0, "R11", "out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(in_ready == '0, "R11", "in_ready idle after reset", in_ready, 0);
        check(out_valid == '0, "R11", "out_valid idle after reset", out_valid, 0);

        // R3: all four valid at once, grants 0,1,2,3
        sink_mode = 0;
        fork
            send(0, 16'd1, 16'd2);
            send(1, 16'd3, 16'd4);
            send(2, 16'd5, 16'd6);
            send(3, 16'd7, 16'd8);
            begin
                @(negedge clk);
                for (int k = 0; k < NPORT; k++) begin
                    #2;
                    check(in_ready == (NPORT'(1) << k), "R3", "grant order all ports", in_ready, 1 << k);
                    check($onehot0(in_ready), "R2", "single grant", in_ready, 1 << k);
                    @(negedge clk);
                end
            end
        join
        drain();

        // R3: ports 1 and 3 only, search resumes at 0
        fork
            send(1, 16'd10, 16'd20);
            send(3, 16'd30, 16'd40);
            begin
                @(negedge clk);
                #2;
                check(in_ready == 4'b0010, "R3", "grant port 1 first", in_ready, 4'b0010);
                @(negedge clk);
                #2;
                check(in_ready == 4'b1000, "R3", "grant port 3 next", in_ready, 4'b1000);
            end
        join
        drain();

        // R4: wraparound sums
        send(3, 16'hFFFF, 16'h0001);
        send(0, 16'h8000, 16'h8000);
        send(2, 16'h1234, 16'h4321);
        drain();

        // R9 / R7 / R1: blocked head fills the pipe, then entry closes
        sink_mode = 1;
        fork
            begin
                send(2, 16'd100, 16'd1);
                send(2, 16'd200, 16'd2);
                send(2, 16'd300, 16'd3);
            end
        join_none
        repeat (6) @(negedge clk);
        #2;
        check(exp_q[2].size() == STAGES, "R9", "items absorbed while blocked", exp_q[2].size(), STAGES);
        check(in_ready == '0, "R9", "entry closed when full", in_ready, 0);
        check(out_valid == 4'b0100, "R6", "only port 2 valid", out_valid, 4'b0100);
        begin
            logic [WIDTH-1:0] held;
            held = out_z[2];
            repeat (2) @(negedge clk);
            #2;
            check(out_z[2] == held && out_valid[2], "R7", "held result stable", out_z[2], held);
            check(exp_q[2].size() == STAGES, "R1", "no response transfer without ready", exp_q[2].size(), STAGES);
        end
        sink_mode = 0;
        wait fork;
        drain();

        // R10: bubble behind a blocked head is filled
        sink_mode = 1;
        send(0, 16'd11, 16'd22);
        repeat (3) @(negedge clk);
        fork
            send(1, 16'd33, 16'd44);
            begin
                @(negedge clk);
                #2;
                check(in_ready == 4'b0010, "R10", "bubble accepts behind blocked head", in_ready, 4'b0010);
            end
        join
        @(negedge clk);
        #2;
        check(out_valid == 4'b0001, "R10", "head still blocked on port 0", out_valid, 4'b0001);
        sink_mode = 0;
        drain();

        // R11: reset with items in flight
        sink_mode = 1;
        send(3, 16'd5, 16'd5);
        send(1, 16'd6, 16'd6);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #2;
        check(out_valid == '0, "R11", "reset empties pipeline", out_valid, 0);
        for (int p = 0; p < NPORT; p++) exp_q[p].delete();
        rst = 1'b0;
        sink_mode = 0;
        fork
            send(2, 16'd1, 16'd1);
            send(0, 16'd2, 16'd2);
            begin
                @(negedge clk);
                #2;
                check(in_ready == 4'b0001, "R11", "search restarts at port 0", in_ready, 4'b0001);
            end
        join
        drain();

        // R8 / R5: random gaps and random backpressure on all ports
        sink_mode = 2;
        fork
            for (int p = 0; p < NPORT; p++) begin
                automatic int pp = p;
                fork
                    for (int i = 0; i < 20; i++) begin
                        repeat ($urandom_range(0, 3)) @(negedge clk);
                        send(pp, WIDTH'($urandom), WIDTH'($urandom));
                    end
                join_none
            end
        join
        wait fork;
        sink_mode = 0;
        drain();
        @(negedge clk);
        #2;
        check(out_valid == '0, "R8", "all results delivered", out_valid, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule